// File: doc/BRIEF.md
# LDPC Bit-Node Update Unit

This unit performs the variable-node half of one iteration of soft message-passing decoding for a single bit node. The bit node can connect to up to four checks. Every cycle in which the valid strobe is high, it takes in three things: the channel log-likelihood ratio (LLR) of the bit, the check-to-bit messages returned in the previous iteration, and a flag that marks the first pass of a decode. Two cycles later it presents the following results:
- one extrinsic bit-to-check message for each connected check;
- the a-posteriori total for the bit;
- the hard decision for the bit.

All LLRs are signed two's complement. A positive value favours bit 0 and a negative value favours bit 1. The unit first forms one inclusive total of the channel value and every active incoming message. It then gets each outgoing message by subtracting that edge's own incoming message from the total. This keeps the adder count linear in the degree. A compile-time degree parameter shuts off unused edges, so that nodes of lower degree can reuse the same hardware.

The datapath is a two-stage pipeline.
- **Stage 1** masks the inputs, sums them and registers the total together with the masked messages.
- **Stage 2** forms the per-edge differences, saturates them and registers every output.

When no strobe arrives, the outputs hold their last values and the output valid flag stays low.

Top module: `ldpc_bitnode_update`

## Requirements
- R1: Each input strobe `in_valid` produces exactly one `out_valid` pulse. The pulse is high in the cycle that follows the second rising clock edge after the strobe is sampled, and for that cycle only.
- R2: For each active edge m, `b2c_msgs` slice m equals the channel LLR plus the sum of every other active incoming message, saturated as in R5. Slice m occupies bits [6m+5:6m], and the same slicing applies to `c2b_msgs`.
- R3: `app_llr` equals the channel LLR plus all active incoming messages. It is a 9-bit two's complement value and is not saturated.
- R4: When `first_pass` is 1, every incoming message is treated as zero. Every active outgoing message then equals the saturated channel LLR, and `app_llr` equals the channel LLR.
- R5: Outgoing messages are 6-bit two's complement values clamped symmetrically to the range -31..+31. For example, a channel value of -32 on a first pass leaves as -31.
- R6: `hard_bit` is 1 exactly when `app_llr` is negative. An `app_llr` of zero gives 0.
- R7: An edge with index at or above the degree parameter `DEG` is ignored. Its input does not contribute to any sum, and its output slice is 0.
- R8: After reset, `out_valid`, `hard_bit`, `app_llr` and every `b2c_msgs` slice are 0.
- R9: With channel LLR -12 and incoming messages -7 and -4 (others 0), `app_llr` is -23 and `hard_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input set is valid this cycle |
| first_pass | input | 1 | First iteration: incoming messages taken as zero |
| ch_llr | input | 6 | Channel LLR, two's complement |
| c2b_msgs | input | 24 | Four check-to-bit messages, edge m at [6m+5:6m] |
| out_valid | output | 1 | Outputs updated this cycle |
| b2c_msgs | output | 24 | Four bit-to-check messages, edge m at [6m+5:6m] |
| app_llr | output | 9 | A-posteriori total, two's complement |
| hard_bit | output | 1 | Hard decision, 1 when the total is negative |

## Verification
The bench walks every channel value against every value of one incoming message, with the other messages derived from those two and first-pass cycles mixed in. This exposes any off-by-one in sign extension or in which message an edge excludes. Such an error shows up as outgoing messages that are wrong by exactly one incoming value, or as a total that is wrong only for negative inputs.

Directed cases drive the total to +155 and -160 and a single edge to -32. A missing or one-sided clamp would then wrap a message to the wrong sign, and an asymmetric clamp would let -32 through. A total of exactly zero catches a decision taken from the wrong side of zero. A second instance built with degree 3, with a live value on its fourth input, shows whether an unused edge leaks into the sums or drives a nonzero output.

// File: rtl/ldpc_bnu_pkg.sv
`timescale 1ns/1ps
package ldpc_bnu_pkg;
    // default message width and node degree
    localparam int MSG_W_DEF  = 6;
    localparam int SUM_W_DEF  = 9;
    localparam int MAXDEG_DEF = 4;

    // largest magnitude an outgoing message may carry
    function automatic int msg_limit(input int w);
        return (1 << (w - 1)) - 1;
    endfunction
endpackage

// File: rtl/bnu_edge_mask.sv
`timescale 1ns/1ps
module bnu_edge_mask
    import ldpc_bnu_pkg::*;
#(
    parameter int MSG_W  = MSG_W_DEF,
    parameter int MAXDEG = MAXDEG_DEF,
    parameter int DEG    = MAXDEG_DEF
) (
    input  logic                              first_pass,
    input  logic [MAXDEG-1:0][MSG_W-1:0]      msgs_in,
    output logic [MAXDEG-1:0][MSG_W-1:0]      msgs_out
);
    // inactive edges and first-pass inputs read as zero
    for (genvar e = 0; e < MAXDEG; e++) begin : g_edge
        if (e < DEG) begin : g_live
            assign msgs_out[e] = first_pass ? '0 : msgs_in[e];
        end else begin : g_dead
            assign msgs_out[e] = '0;
        end
    end
endmodule

// File: rtl/bnu_accum.sv
`timescale 1ns/1ps
module bnu_accum
    import ldpc_bnu_pkg::*;
#(
    parameter int MSG_W  = MSG_W_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int MAXDEG = MAXDEG_DEF
) (
    input  logic [MSG_W-1:0]                  chan,
    input  logic [MAXDEG-1:0][MSG_W-1:0]      msgs,
    output logic signed [SUM_W-1:0]           total
);
    localparam int EXT = SUM_W - MSG_W;

    always_comb begin
        total = $signed({{EXT{chan[MSG_W-1]}}, chan});
        for (int e = 0; e < MAXDEG; e++) begin
            total = total + $signed({{EXT{msgs[e][MSG_W-1]}}, msgs[e]});
        end
    end
endmodule

// File: rtl/bnu_extr.sv
`timescale 1ns/1ps
module bnu_extr
    import ldpc_bnu_pkg::*;
#(
    parameter int MSG_W  = MSG_W_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int MAXDEG = MAXDEG_DEF,
    parameter int DEG    = MAXDEG_DEF
) (
    input  logic signed [SUM_W-1:0]           total,
    input  logic [MAXDEG-1:0][MSG_W-1:0]      msgs,
    output logic [MAXDEG-1:0][MSG_W-1:0]      extr
);
    localparam int EXT = SUM_W - MSG_W;
    localparam int LIM = msg_limit(MSG_W);

    for (genvar e = 0; e < MAXDEG; e++) begin : g_edge
        if (e < DEG) begin : g_live
            logic signed [SUM_W-1:0] diff;
            always_comb begin
                // total minus the message this edge's check sent
                diff = total - $signed({{EXT{msgs[e][MSG_W-1]}}, msgs[e]});
                if (diff > LIM)
                    extr[e] = MSG_W'(LIM);
                else if (diff < -LIM)
                    extr[e] = MSG_W'(-LIM);
                else
                    extr[e] = diff[MSG_W-1:0];
            end
        end else begin : g_dead
            assign extr[e] = '0;
        end
    end
endmodule

// File: rtl/ldpc_bitnode_update.sv
`timescale 1ns/1ps
module ldpc_bitnode_update
    import ldpc_bnu_pkg::*;
#(
    parameter int MSG_W  = MSG_W_DEF,
    parameter int SUM_W  = SUM_W_DEF,
    parameter int MAXDEG = MAXDEG_DEF,
    parameter int DEG    = MAXDEG_DEF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        first_pass,
    input  logic [MSG_W-1:0]            ch_llr,
    input  logic [MAXDEG*MSG_W-1:0]     c2b_msgs,
    output logic                        out_valid,
    output logic [MAXDEG*MSG_W-1:0]     b2c_msgs,
    output logic [SUM_W-1:0]            app_llr,
    output logic                        hard_bit
);
    localparam int LIM     = msg_limit(MSG_W);
    localparam int APP_MAX = (MAXDEG + 1) * (1 << (MSG_W - 1));

    logic [MAXDEG-1:0][MSG_W-1:0] msgs_raw, msgs_live, msgs_q, extr_d, extr_q;
    logic signed [SUM_W-1:0]      total_d, total_q, app_q;
    logic                         v1_q, v2_q, hard_q;

    assign msgs_raw = c2b_msgs;

    bnu_edge_mask #(.MSG_W(MSG_W), .MAXDEG(MAXDEG), .DEG(DEG)) u_mask (
        .first_pass (first_pass),
        .msgs_in    (msgs_raw),
        .msgs_out   (msgs_live)
    );

    bnu_accum #(.MSG_W(MSG_W), .SUM_W(SUM_W), .MAXDEG(MAXDEG)) u_accum (
        .chan  (ch_llr),
        .msgs  (msgs_live),
        .total (total_d)
    );

    // stage 1: inclusive total and the masked messages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q    <= 1'b0;
            total_q <= '0;
            msgs_q  <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                total_q <= total_d;
                msgs_q  <= msgs_live;
            end
        end
    end

    bnu_extr #(.MSG_W(MSG_W), .SUM_W(SUM_W), .MAXDEG(MAXDEG), .DEG(DEG)) u_extr (
        .total (total_q),
        .msgs  (msgs_q),
        .extr  (extr_d)
    );

    // stage 2: saturated extrinsics, total and decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q   <= 1'b0;
            extr_q <= '0;
            app_q  <= '0;
            hard_q <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                extr_q <= extr_d;
                app_q  <= total_q;
                hard_q <= total_q[SUM_W-1];
            end
        end
    end

    assign out_valid = v2_q;
    assign b2c_msgs  = extr_q;
    assign app_llr   = app_q;
    assign hard_bit  = hard_q;

    // R1: two-cycle latency
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R3: total stays within the reachable range
    p_app_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(app_q) <= APP_MAX && $signed(app_q) >= -APP_MAX));

    // R6: zero total decides bit 0
    p_zero_hard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && app_q == '0) |-> !hard_bit);

    for (genvar e = 0; e < MAXDEG; e++) begin : g_chk
        // R5: symmetric clamp on every outgoing message
        p_sat_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> ($signed(extr_q[e]) <= LIM && $signed(extr_q[e]) >= -LIM));
        if (e >= DEG) begin : g_dead_chk
            // R7: disabled edge output is zero
            p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (b2c_msgs[e*MSG_W +: MSG_W] == '0));
        end
    end
endmodule

// File: tb/tb_ldpc_bitnode_update.sv
`timescale 1ns/1ps
module tb_ldpc_bitnode_update;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        first_pass = 1'b0;
    logic [5:0]  ch_llr = '0;
    logic [23:0] c2b_msgs = '0;
    logic        out_valid, out_valid3, hard_bit, hard_bit3;
    logic [23:0] b2c_msgs, b2c_msgs3;
    logic [8:0]  app_llr, app_llr3;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ldpc_bitnode_update dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pass(first_pass),
        .ch_llr(ch_llr), .c2b_msgs(c2b_msgs), .out_valid(out_valid),
        .b2c_msgs(b2c_msgs), .app_llr(app_llr), .hard_bit(hard_bit)
    );

    ldpc_bitnode_update #(.DEG(3)) dut_d3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .first_pass(first_pass),
        .ch_llr(ch_llr), .c2b_msgs(c2b_msgs), .out_valid(out_valid3),
        .b2c_msgs(b2c_msgs3), .app_llr(app_llr3), .hard_bit(hard_bit3)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp31(input int v);
        if (v > 31) return 31;
        if (v < -31) return -31;
        return v;
    endfunction

    function automatic int sl(input logic [23:0] bus, input int e);
        return int'($signed(bus[e*6 +: 6]));
    endfunction

    // drive one set, then check both instances against arithmetic model
    task automatic run(input int ch, input int m0, input int m1, input int m2,
                       input int m3, input bit fp, input string req);
        int m[4];
        int deg, tot, ex;
        m[0] = m0; m[1] = m1; m[2] = m2; m[3] = m3;
        @(negedge clk);
        ch_llr     = 6'(ch);
        c2b_msgs   = {6'(m3), 6'(m2), 6'(m1), 6'(m0)};
        first_pass = fp;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "out_valid after one edge", int'(out_valid), 0);
        @(negedge clk);
        chk("R1", "out_valid after two edges", int'(out_valid), 1);
        for (int d = 0; d < 2; d++) begin
            deg = (d == 0) ? 4 : 3;
            tot = ch;
            for (int e = 0; e < deg; e++) if (!fp) tot += m[e];
            chk(fp ? "R4" : "R3", d == 0 ? "app deg4" : "app deg3",
                int'($signed(d == 0 ? app_llr : app_llr3)), tot);
            chk("R6", "hard", int'(d == 0 ? hard_bit : hard_bit3), tot < 0 ? 1 : 0);
            for (int e = 0; e < 4; e++) begin
                if (e < deg) ex = clamp31(tot - (fp ? 0 : m[e]));
                else ex = 0;
                chk(e >= deg ? "R7" : (fp ? "R4" : "R2"), "b2c edge",
                    sl(d == 0 ? b2c_msgs : b2c_msgs3, e), ex);
            end
        end
        chk(req, "directed valid", int'(out_valid3), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        chk("R8", "out_valid", int'(out_valid), 0);
        chk("R8", "hard", int'(hard_bit), 0);
        chk("R8", "app", int'(app_llr), 0);
        chk("R8", "b2c", int'(b2c_msgs != 0), 0);
        // R9: worked case
        run(-12, -7, -4, 0, 0, 1'b0, "R9");
        chk("R9", "app worked case", int'($signed(app_llr)), -23);
        chk("R9", "hard worked case", int'(hard_bit), 1);
        // R5: positive and negative saturation, asymmetric corner
        run(31, 31, 31, 31, 31, 1'b0, "R5");
        run(-32, -32, -32, -32, -32, 1'b0, "R5");
        run(-32, 17, 9, -3, 4, 1'b1, "R5");
        chk("R5", "first pass -32 clamps", sl(b2c_msgs, 0), -31);
        // R6: exact zero total
        run(5, -5, 0, 0, 0, 1'b0, "R6");
        chk("R6", "zero total hard", int'(hard_bit), 0);
        // R7: live value on the disabled fourth edge
        run(3, 2, -1, 4, 25, 1'b0, "R7");
        // R2/R3/R4: sweep channel against edge 0
        for (int c = -32; c < 32; c++) begin
            for (int a = -32; a < 32; a++) begin
                run(c, a,
                    ((a * 7 + c * 3 + 1005) % 64) - 32,
                    ((a * 11 + c + 1077) % 64) - 32,
                    ((a * 5 - c * 13 + 2000) % 64) - 32,
                    ((a + c + 64) % 16) == 0, "R2");
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule